// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block behaves like a small three-wire serial nonvolatile memory as seen from its pins. It holds 1 Kbit of storage in registers, arranged as 64 words of 16 bits or, when the organization strap is low, as 128 bytes. A fast system clock samples the chip-select, serial-clock and data-in pins. Edges of the serial clock are found inside the block, so the host may drive the pins from any slower source.

A host raises chip select and shifts in a frame on rising serial-clock edges. The frame is a 1 start bit, a two-bit operation code, an address and, for the two data-carrying commands, a data field. Read returns one zero bit and then the addressed word. The block keeps streaming the following words for as long as the clock runs.

Commands that modify storage are held back until chip select falls. They then run for a fixed number of system clocks. A host that selects the block during that time sees a busy/ready flag on the data-out pin. A lock that is set at reset blocks every modifying command until it is released.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, do_oe is low, every storage bit reads back as 1, and the modify lock is engaged.
- R2: A frame begins with the first 1 sampled on a rising serial-clock edge while chip select is high; 0 bits before it are ignored. Then follow a 2-bit opcode (MSB first), the address (MSB first), and the data (MSB first) for write and write-all.
- R3: Opcode 10 is read. After the last address bit, do_oe rises and one 0 bit is driven, then the word MSB first, each bit changing after a rising serial-clock edge.
- R4: While chip select stays high, a read continues with the next address and no further 0 bit. Past the top address it wraps to 0 (63→0 for words, 127→0 for bytes).
- R5: Opcode 00 with the two top address bits 11 releases the lock, and 00 re-engages it. While locked, write, erase, erase-all and write-all have no effect on storage. Reads work in either state.
- R6: Opcode 01 writes the data to the addressed location without a prior erase. The change starts on the falling edge of chip select and lasts PROG_CYCLES system clocks.
- R7: Opcode 11 sets the addressed location to all ones. Opcode 00 with top bits 10 sets every location to all ones. Opcode 00 with top bits 01 writes the data field to every location.
- R8: While a change runs and chip select is high, the block drives do_o low; once the change has finished it drives do_o high. A 1 shifted in on a rising edge then releases do_oe after the next falling serial-clock edge.
- R9: Any frame received while a change is running is ignored.
- R10: Chip select low aborts a partial frame, and a write frame cut short starts no change.
- R11: org16=1 selects 16-bit words with 6-bit addresses. org16=0 selects bytes with 7-bit addresses and 8-bit data, where address bit 0 = 1 picks the high half of word address[6:1]. The strap is sampled only while chip select is low.
- R12: do_oe is low whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| org16 | input | 1 | Organization strap: 1 = 16-bit words, 0 = bytes |
| do_o | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for do_o; low means high impedance |

## Verification
A wrong bit count or opcode decode shows up on the first read, as a missing leading zero or data shifted by one position. It appears within one word time. A program cycle that starts at the wrong moment, or lasts the wrong length, shows as a busy flag that is absent or clears too early or too late. That is visible on the next chip-select rise. A lock or busy guard that leaks shows up later, as changed storage on a following read. For that reason the bench reads back every location it expects to be untouched.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_BITS   = 6,
  parameter int PROG_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org16,
  output logic do_o,
  output logic do_oe
);
  localparam int WORDS = 1 << ADDR_BITS;
  localparam int AW8   = ADDR_BITS + 1;
  localparam int CW    = $clog2(2 + AW8 + 16 + 1);
  localparam int PW    = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_READ, S_HOLD} st_t;
  typedef enum logic [2:0] {P_NONE, P_WRITE, P_ERASE, P_ERAL, P_WRAL} pk_t;

  logic [2:0] cs_p, sk_p;
  logic [1:0] di_p;
  logic cs_s, cs_d, di_s, sk_rise, sk_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p <= '0; sk_p <= '0; di_p <= '0;
    end else begin
      cs_p <= {cs_p[1:0], cs};
      sk_p <= {sk_p[1:0], sk};
      di_p <= {di_p[0], di};
    end

  assign cs_s    = cs_p[1];
  assign cs_d    = cs_p[2];
  assign di_s    = di_p[1];
  assign sk_rise = sk_p[1] & ~sk_p[2];
  assign sk_fall = ~sk_p[1] & sk_p[2];

  logic [15:0] mem [WORDS];
  st_t st;
  pk_t pend;
  logic org_q, p_org, wen, busy, oe_rd, dout, status_on, status_arm, hz_pend;
  logic [CW-1:0] cnt, addr_last, data_last;
  logic [14:0] sr;
  logic [15:0] nxt, out_sr, wdata;
  logic [1:0] op, top2;
  logic [AW8-1:0] addr, addr_in, addr_nx, widx_src;
  logic [ADDR_BITS-1:0] widx;
  logic [4:0] left;
  logic [PW-1:0] pcnt;
  logic prog_done;

  assign nxt       = {sr, di_s};
  assign addr_last = org_q ? CW'(1 + ADDR_BITS) : CW'(1 + AW8);
  assign data_last = org_q ? CW'(1 + ADDR_BITS + 16) : CW'(1 + AW8 + 8);
  assign addr_in   = org_q ? {1'b0, nxt[ADDR_BITS-1:0]} : nxt[AW8-1:0];
  assign top2      = org_q ? nxt[ADDR_BITS-1 -: 2] : nxt[AW8-1 -: 2];
  assign addr_nx   = org_q ? {1'b0, ADDR_BITS'(addr[ADDR_BITS-1:0] + 1'b1)} : AW8'(addr + 1'b1);
  assign prog_done = busy && (pcnt == '0);
  assign widx_src  = addr;
  assign widx      = p_org ? widx_src[ADDR_BITS-1:0] : widx_src[AW8-1:1];

  assign do_oe = oe_rd | status_on;
  assign do_o  = oe_rd ? dout : ~busy;

  function automatic logic [15:0] rd_word(input logic [AW8-1:0] a, input logic o);
    logic [15:0] w;
    w = o ? mem[a[ADDR_BITS-1:0]] : mem[a[AW8-1:1]];
    return o ? w : {(a[0] ? w[15:8] : w[7:0]), 8'h00};
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; pend <= P_NONE; org_q <= 1'b1; p_org <= 1'b1; wen <= 1'b0;
      busy <= 1'b0; oe_rd <= 1'b0; dout <= 1'b0; status_on <= 1'b0;
      status_arm <= 1'b0; hz_pend <= 1'b0; cnt <= '0; sr <= '0; op <= '0;
      addr <= '0; wdata <= '0; out_sr <= '0; left <= '0; pcnt <= '0;
    end else begin
      if (busy) begin
        if (pcnt == '0) begin
          busy <= 1'b0;
          pend <= P_NONE;
        end else pcnt <= pcnt - 1'b1;
      end
      if (!cs_s) begin
        org_q <= org16;
        st <= S_IDLE; cnt <= '0; oe_rd <= 1'b0; status_on <= 1'b0; hz_pend <= 1'b0;
        if (cs_d && pend != P_NONE && !busy) begin
          busy <= 1'b1;
          pcnt <= PW'(PROG_CYCLES - 1);
          p_org <= org_q;
          status_arm <= 1'b1;
        end
      end else begin
        if (!cs_d && status_arm) status_on <= 1'b1;
        if (sk_rise) begin
          if (status_on && di_s) hz_pend <= 1'b1;
          case (st)
            S_IDLE: if (di_s && !busy) begin
              st <= S_CMD;
              cnt <= '0;
            end
            S_CMD: begin
              sr <= nxt[14:0];
              cnt <= cnt + 1'b1;
              if (cnt == CW'(1)) op <= nxt[1:0];
              if (cnt == addr_last) begin
                addr <= addr_in;
                case (op)
                  2'b10: begin
                    st <= S_READ; oe_rd <= 1'b1; dout <= 1'b0;
                    out_sr <= rd_word(addr_in, org_q);
                    left <= org_q ? 5'd16 : 5'd8;
                  end
                  2'b01: st <= S_DATA;
                  2'b11: begin
                    st <= S_HOLD;
                    if (wen) pend <= P_ERASE;
                  end
                  default: begin
                    st <= S_HOLD;
                    case (top2)
                      2'b11: wen <= 1'b1;
                      2'b00: wen <= 1'b0;
                      2'b10: if (wen) pend <= P_ERAL;
                      default: st <= S_DATA;
                    endcase
                  end
                endcase
              end
            end
            S_DATA: begin
              sr <= nxt[14:0];
              cnt <= cnt + 1'b1;
              if (cnt == data_last) begin
                wdata <= org_q ? nxt : {8'h00, nxt[7:0]};
                st <= S_HOLD;
                if (wen) pend <= (op == 2'b01) ? P_WRITE : P_WRAL;
              end
            end
            S_READ: begin
              if (left != '0) begin
                dout <= out_sr[15];
                out_sr <= {out_sr[14:0], 1'b0};
                left <= left - 1'b1;
              end else begin
                dout <= rd_word(addr_nx, org_q)[15];
                out_sr <= {rd_word(addr_nx, org_q)[14:0], 1'b0};
                left <= org_q ? 5'd15 : 5'd7;
                addr <= addr_nx;
              end
            end
            default: ;
          endcase
        end
        if (sk_fall && hz_pend) begin
          status_on <= 1'b0;
          status_arm <= 1'b0;
          hz_pend <= 1'b0;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
    end else if (prog_done) begin
      case (pend)
        P_WRITE:
          if (p_org) mem[widx] <= wdata;
          else if (addr[0]) mem[widx][15:8] <= wdata[7:0];
          else mem[widx][7:0] <= wdata[7:0];
        P_ERASE:
          if (p_org) mem[widx] <= 16'hFFFF;
          else if (addr[0]) mem[widx][15:8] <= 8'hFF;
          else mem[widx][7:0] <= 8'hFF;
        P_ERAL:
          for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
        P_WRAL:
          for (int i = 0; i < WORDS; i++) mem[i] <= p_org ? wdata : {wdata[7:0], wdata[7:0]};
        default: ;
      endcase
    end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic cs_d,
  input logic busy,
  input logic wen,
  input logic org_q,
  input logic do_o,
  input logic do_oe
);
  // R12
  cs_low_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs_s |=> !do_oe);
  // R6
  prog_on_cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(cs_d && !cs_s));
  // R5
  prog_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(wen));
  // R8
  busy_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && do_oe && !$rose(do_oe)) |-> !do_o || $past(do_oe && !busy));
  // R11
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_s |=> $stable(org_q));
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_d(cs_d), .busy(busy),
  .wen(wen), .org_q(org_q), .do_o(do_o), .do_oe(do_oe)
);

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
  localparam int PROG = 1000;
  logic clk = 0, rst_n = 0, cs = 0, sk = 0, di = 0, org16 = 1;
  logic do_o, do_oe, s_do, s_oe;
  int n_chk = 0, n_fail = 0;
  logic [15:0] ref16 [64];
  bit ref_wen = 0, done = 0;

  always #10 clk = ~clk;

  mw_eeprom #(.ADDR_BITS(6), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org16(org16),
    .do_o(do_o), .do_oe(do_oe));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b);
    di = b; tick(6);
    sk = 1; tick(5);
    s_do = do_o; s_oe = do_oe;
    tick(1);
    sk = 0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
  endtask

  function automatic int aw(input bit o); return o ? 6 : 7; endfunction
  function automatic int dw(input bit o); return o ? 16 : 8; endfunction

  function automatic logic [15:0] m_read(input bit o, input int a);
    logic [15:0] w;
    if (o) return ref16[a & 63];
    w = ref16[(a & 127) >> 1];
    return (a & 1) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  function automatic void m_write(input bit o, input int a, input logic [15:0] d);
    if (!ref_wen) return;
    if (o) ref16[a & 63] = d;
    else if (a & 1) ref16[(a & 127) >> 1][15:8] = d[7:0];
    else ref16[(a & 127) >> 1][7:0] = d[7:0];
  endfunction

  task automatic set_org(input bit o);
    org16 = o; tick(4);
  endtask

  task automatic frame_end(input bit prog);
    cs = 0; tick(10);
    if (prog) tick(PROG + 50);
  endtask

  task automatic special(input bit o, input logic [1:0] sub);
    cs = 1; tick(4);
    send(3'b100, 3);
    send({sub, 5'b0} >> (7 - aw(o)), aw(o));
  endtask

  task automatic wr(input bit o, input int a, input logic [15:0] d, input bit st);
    cs = 1; tick(4);
    send(3'b101, 3); send(a, aw(o)); send(d, dw(o));
    m_write(o, a, d);
    cs = 0; tick(10);
    if (st) begin
      cs = 1; tick(8);
      // R8 busy flag
      check(do_oe === 1 && do_o === (ref_wen ? 1'b0 : 1'b1), "R8 busy", {do_oe, do_o}, {1'b1, !ref_wen});
      tick(PROG + 50);
      // R8 ready flag
      check(do_oe === 1 && do_o === 1, "R8 ready", {do_oe, do_o}, 2'b11);
      clk_bit(1); tick(8);
      // R8 release to high impedance
      check(do_oe === 0, "R8 hiz", do_oe, 0);
      frame_end(0);
    end else tick(PROG + 50);
  endtask

  task automatic rd(input bit o, input int a, input int n, input string req);
    logic [15:0] got;
    cs = 1; tick(4);
    send(3'b110, 3); send(a, aw(o));
    check(s_oe === 1 && s_do === 0, {req, " R3 dummy"}, {s_oe, s_do}, 2'b10);
    for (int k = 0; k < n; k++) begin
      got = '0;
      for (int b = dw(o) - 1; b >= 0; b--) begin
        clk_bit(0);
        got[b] = s_do;
      end
      check(got === m_read(o, a + k), req, got, m_read(o, a + k));
    end
    frame_end(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) ref16[i] = 16'hFFFF;
    void'($urandom(32'd1234));
    tick(3); rst_n = 1; tick(5);
    // R1 reset state
    check(do_oe === 0, "R1 oe", do_oe, 0);
    rd(1, 5, 1, "R1 erased");
    // R5 locked write ignored
    wr(1, 3, 16'h1234, 0);
    rd(1, 3, 1, "R5 locked");
    special(1, 2'b11); frame_end(0); ref_wen = 1;
    wr(1, 3, 16'h1234, 1);
    rd(1, 3, 1, "R6 write");
    wr(1, 3, 16'hC0DE, 0);
    rd(1, 3, 1, "R6 overwrite");
    // R2 leading zeros before start bit
    cs = 1; tick(4); send(3'b000, 3); frame_end(0);
    cs = 1; tick(4); send(2'b00, 2);
    send(3'b110, 3); send(3, 6);
    check(s_oe === 1 && s_do === 0, "R2 start", {s_oe, s_do}, 2'b10);
    frame_end(0);
    // R4 sequential read with wrap
    wr(1, 62, 16'h6262, 0); wr(1, 63, 16'h6363, 0); wr(1, 0, 16'h0A0A, 0);
    rd(1, 62, 3, "R4 wrap");
    // R9 frame during busy ignored
    wr(1, 10, 16'hAAAA, 0);
    cs = 1; tick(4); send(3'b101, 3); send(10, 6); send(16'h5555, 16); frame_end(0);
    cs = 1; tick(4); send(3'b101, 3); send(11, 6); send(16'h5555, 16);
    tick(PROG);
    frame_end(0);
    ref16[10] = 16'hAAAA;
    cs = 1; tick(4); send(3'b101, 3); send(10, 6); send(16'hAAAA, 16); frame_end(1);
    rd(1, 11, 1, "R9 busy ignore");
    // R7 single erase
    cs = 1; tick(4); send(3'b111, 3); send(3, 6); frame_end(1);
    ref16[3] = 16'hFFFF;
    rd(1, 3, 1, "R7 erase");
    // R10 aborted write
    wr(1, 20, 16'h2020, 1);
    cs = 1; tick(4); send(3'b101, 3); send(20, 6); send(8'h77, 8); frame_end(0);
    cs = 1; tick(8);
    check(do_oe === 0, "R10 no prog", do_oe, 0);
    frame_end(0);
    rd(1, 20, 1, "R10 abort");
    // R11 byte organization
    set_org(0);
    wr(0, 9, 16'h005A, 0);
    rd(0, 9, 1, "R11 high byte");
    rd(0, 8, 1, "R11 low byte");
    rd(0, 127, 2, "R11 R4 byte wrap");
    set_org(1);
    rd(1, 4, 1, "R11 word view");
    cs = 1; tick(2); org16 = 0; tick(4);
    send(3'b110, 3); send(4, 6);
    got_one: begin
      logic [15:0] g;
      g = '0;
      for (int b = 15; b >= 0; b--) begin clk_bit(0); g[b] = s_do; end
      check(g === ref16[4], "R11 strap frozen", g, ref16[4]);
    end
    cs = 0; org16 = 1; tick(10);
    // R12 chip select drop mid-read
    cs = 1; tick(4); send(3'b110, 3); send(3, 6); clk_bit(0);
    cs = 0; tick(6);
    check(do_oe === 0, "R12 cs low", do_oe, 0);
    tick(4);
    // R7 write-all and erase-all
    special(1, 2'b01); send(16'h0F0F, 16); frame_end(1);
    for (int i = 0; i < 64; i++) ref16[i] = 16'h0F0F;
    rd(1, 17, 2, "R7 write all");
    special(1, 2'b10); frame_end(1);
    for (int i = 0; i < 64; i++) ref16[i] = 16'hFFFF;
    rd(1, 40, 2, "R7 erase all");
    // random traffic
    for (int it = 0; it < 14; it++) begin
      bit o;
      int a;
      logic [15:0] d;
      o = $urandom_range(0, 1);
      a = $urandom_range(0, o ? 63 : 127);
      d = 16'($urandom);
      set_org(o);
      wr(o, a, d, 0);
      rd(o, a, 2, "R6 R4 random");
    end
    set_org(1);
    // R5 relock
    special(1, 2'b00); frame_end(0); ref_wen = 0;
    wr(1, 30, 16'hBEEF, 0);
    rd(1, 30, 1, "R5 relock");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule